// File: doc/BRIEF.md
# Triggered PWM Pulse Timer

This block is a 16-bit pulse timer that stays idle until a chosen edge arrives on an external trigger pin. From that edge it runs a counter and produces a pulse-width-modulated waveform. One register sets the length of each PWM cycle and a second sets how long the pulse stays active. Any later valid trigger edge restarts the waveform from the beginning. This lets a system event start a pulse train that is aligned to that event, for example a motor commutation or a sensor strobe.

The counter normally steps on a one-cycle count enable supplied from outside, so prescaling is not part of this block. It can instead step on chosen edges of an external event pin. There are two outputs. The first toggles once per PWM cycle, and when disabled it holds a programmable idle level. The second carries the pulse and has a programmable polarity. A small synchronous register port holds the configuration and lets software read the live counter.

Top module: `trig_pwm_timer`

## Requirements
- R1: With period value P, the counter steps through 0, 1, ..., P and returns to 0 on the step after reaching P, so one PWM cycle lasts P+1 steps. P=0 gives a one-step cycle.
- R2: With width value W, the pulse on `pwm1` is active while the count is below W. It is active for W steps of each cycle, never active when W=0, and always active when W>P.
- R3: `pwm1` polarity is set by control bit 3: 0 means active-high and 1 means active-low. When `pwm1` is disabled (control bit 2 = 0), it holds the inactive level, which equals the polarity bit.
- R4: When enabled (control bit 0 = 1), `pwm0` shows a toggle flag. The flag inverts each time the counter wraps and is cleared by every valid trigger edge.
- R5: When disabled (control bit 0 = 0), `pwm0` drives the level in control bit 1.
- R6: Both pins pass through a two-flop synchronizer before edge detection. The trigger edge select is control bits 5:4, coded 00 none, 01 rising, 10 falling, 11 both. The count is 0 after the third rising clock edge that follows a valid trigger pin change.
- R7: When control bit 8 = 1, the counter steps on valid event-pin edges selected by control bits 7:6, using the same coding as R6, and `cnt_tick` is ignored.
- R8: Before the first valid trigger edge after reset, the count stays 0 even when step events occur, and `pwm1` stays inactive.
- R9: When control bit 8 = 0, a started counter steps only on clocks where `cnt_tick` is 1.
- R10: New period and width values are used only from the next wrap or trigger edge. A cycle already running keeps its values.
- R11: The register map is: address 0 control (bits 8:0), 1 period, 2 width, 3 live count. `rdata` is combinational on `addr`. Writes to address 3 have no effect.
- R12: After a synchronous low `rst_n`, every register and the count are 0, and `pwm0` and `pwm1` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | One-cycle count enable |
| trig_in | input | 1 | External trigger pin (asynchronous) |
| evt_in | input | 1 | External event-count pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pwm0 | output | 1 | Toggle output or idle level |
| pwm1 | output | 1 | PWM pulse output |

## Verification
The bound assertions check, on every clock, the properties that hold at each edge: the count never exceeds the latched period, the count stays 0 until the first trigger, a trigger forces the count to 0, the count holds when no step occurs, latched values hold mid-cycle, and disabled outputs show their static levels. The real timing behaviour only appears in the bench scenarios, which compare every clock against a cycle model. This covers the exact pulse length per cycle, the three-edge trigger latency, the toggle sequence of `pwm0`, event-edge counting, and the deferred use of new period and width values.

// File: rtl/tpw_pkg.sv
// Package: shared types and register addresses for the triggered PWM timer.
// Assumes control data fits in the low bits of the register data word.
package tpw_pkg;

    // Edge select coding used for both the trigger and event pins
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Control register layout, MSB first (bit 8 .. bit 0)
    typedef struct packed {
        logic      cnt_src;   // 1: step on event edges, 0: step on cnt_tick
        edge_sel_e evt_sel;   // event pin edge select
        edge_sel_e trig_sel;  // trigger pin edge select
        logic      pol1;      // pwm1 polarity, 1 = active-low
        logic      oe1;       // pwm1 enable
        logic      idle0;     // pwm0 level while disabled
        logic      oe0;       // pwm0 enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_PERIOD = 2'd1;
    localparam logic [1:0] A_WIDTH  = 2'd2;
    localparam logic [1:0] A_COUNT  = 2'd3;

endpackage

// File: rtl/tpw_edge_det.sv
// Edge detector: synchronizes an asynchronous pin through SYNC_STAGES flops
// and produces a one-cycle pulse on the edge kind chosen by sel.
// Assumes SYNC_STAGES >= 2.
module tpw_edge_det
    import tpw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      edge_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;

    // Shift the pin through the synchronizer and keep the last synced value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin};
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    // Pick the edge kind requested by the select field
    always_comb begin
        unique case (sel)
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tpw_regs.sv
// Register file: holds control, period and width, and returns the selected
// register or the live count on rdata. Assumes DATA_W >= CTRL_W.
module tpw_regs
    import tpw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] period_o,
    output logic [DATA_W-1:0] width_o,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - CTRL_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] width_q;

    // Capture writes; the count address is read-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            width_q  <= '0;
        end else if (wr_en) begin
            case (addr[1:0])
                A_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
                A_PERIOD: period_q <= wdata;
                A_WIDTH:  width_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (addr[1:0])
            A_CTRL:   rdata = {{PAD_W{1'b0}}, ctrl_q};
            A_PERIOD: rdata = period_q;
            A_WIDTH:  rdata = width_q;
            default:  rdata = count;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign period_o = period_q;
    assign width_o  = width_q;

endmodule

// File: rtl/tpw_core.sv
// Timer core: after a trigger edge, steps a counter from 0 to the latched
// period, latches new period and width values at each wrap, and forms both
// outputs. Assumes trig_edge and evt_edge are single-cycle synchronous pulses.
module tpw_core
    import tpw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             cnt_tick,
    input  logic             trig_edge,
    input  logic             evt_edge,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] per_act,
    output logic             started,
    output logic             adv,
    output logic             pwm0,
    output logic             pwm1
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_act_q;
    logic [CNT_W-1:0] wid_act_q;
    logic             started_q;
    logic             tog_q;
    logic             wrap;
    logic             active;

    assign adv  = started_q & (ctrl.cnt_src ? evt_edge : cnt_tick);
    assign wrap = adv & (cnt_q == per_act_q);

    // Counter, running flag, toggle flag and latched cycle values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            per_act_q <= '0;
            wid_act_q <= '0;
            started_q <= 1'b0;
            tog_q     <= 1'b0;
        end else if (trig_edge) begin
            cnt_q     <= '0;
            per_act_q <= period;
            wid_act_q <= width;
            started_q <= 1'b1;
            tog_q     <= 1'b0;
        end else if (wrap) begin
            cnt_q     <= '0;
            per_act_q <= period;
            wid_act_q <= width;
            tog_q     <= ~tog_q;
        end else if (adv) begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    assign active = started_q & (cnt_q < wid_act_q);

    // Output level selection
    always_comb begin
        pwm0 = ctrl.oe0 ? tog_q : ctrl.idle0;
        pwm1 = ctrl.oe1 ? (active ^ ctrl.pol1) : ctrl.pol1;
    end

    assign count   = cnt_q;
    assign per_act = per_act_q;
    assign started = started_q;

endmodule

// File: rtl/trig_pwm_timer.sv
// Top: externally triggered PWM pulse timer. Connects two edge detectors,
// the register file and the timer core. Assumes all inputs except trig_in
// and evt_in are synchronous to clk.
module trig_pwm_timer
    import tpw_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              trig_in,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pwm0,
    output logic              pwm1
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] per_act;
    logic             started;
    logic             adv;
    logic             trig_edge;
    logic             evt_edge;

    tpw_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_trig_det (
        .clk(clk), .rst_n(rst_n), .pin(trig_in),
        .sel(ctrl.trig_sel), .edge_o(trig_edge)
    );

    tpw_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_evt_det (
        .clk(clk), .rst_n(rst_n), .pin(evt_in),
        .sel(ctrl.evt_sel), .edge_o(evt_edge)
    );

    tpw_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .count(count), .ctrl_o(ctrl),
        .period_o(period), .width_o(width), .rdata(rdata)
    );

    tpw_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .period(period),
        .width(width), .cnt_tick(cnt_tick), .trig_edge(trig_edge),
        .evt_edge(evt_edge), .count(count), .per_act(per_act),
        .started(started), .adv(adv), .pwm0(pwm0), .pwm1(pwm1)
    );

endmodule

// File: rtl/trig_pwm_timer_chk.sv
// Checker: clocked properties of the triggered PWM timer, bound to the top.
module trig_pwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] per_act,
    input logic             started,
    input logic             adv,
    input logic             trig_edge,
    input logic             oe0,
    input logic             idle0,
    input logic             oe1,
    input logic             pol1,
    input logic             pwm0,
    input logic             pwm1
);

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> count <= per_act);

    assert_idle_before_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (count == '0 && pwm1 == pol1));

    assert_trig_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |=> (count == '0 && started));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_edge && !adv) |=> $stable(count));

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_edge && !(adv && count == per_act)) |=> $stable(per_act));

    assert_pwm0_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe0 |-> pwm0 == idle0);

    assert_pwm1_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !oe1 |-> pwm1 == pol1);

endmodule

bind trig_pwm_timer trig_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .per_act(per_act),
    .started(started), .adv(adv), .trig_edge(trig_edge),
    .oe0(ctrl.oe0), .idle0(ctrl.idle0), .oe1(ctrl.oe1), .pol1(ctrl.pol1),
    .pwm0(pwm0), .pwm1(pwm1)
);

// File: tb/trig_pwm_timer_tb.sv
module trig_pwm_timer_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b0;
    logic         trig_in = 1'b0;
    logic         evt_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd3;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         pwm0;
    logic         pwm1;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    trig_pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .trig_in(trig_in),
        .evt_in(evt_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm0(pwm0), .pwm1(pwm1)
    );

    // Reference model state
    logic [8:0]   m_ctrl;
    logic [W-1:0] m_per, m_wid, m_cnt, m_pa, m_wa;
    logic         m_run, m_tog;
    logic         m_t1, m_t2, m_tp, m_e1, m_e2, m_ep;

    function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prv);
        case (sel)
            2'b01:   return cur & ~prv;
            2'b10:   return ~cur & prv;
            2'b11:   return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_pwm0();
        return m_ctrl[0] ? m_tog : m_ctrl[1];
    endfunction

    function automatic logic exp_pwm1();
        logic act;
        act = m_run && (m_cnt < m_wa);
        return m_ctrl[2] ? (act ^ m_ctrl[3]) : m_ctrl[3];
    endfunction

    function automatic logic [W-1:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {7'd0, m_ctrl};
            2'd1:    return m_per;
            2'd2:    return m_wid;
            default: return m_cnt;
        endcase
    endfunction

    // Cycle model of the timer, advanced at each rising edge
    always @(posedge clk) begin
        logic te, ee, st;
        if (!rst_n) begin
            m_ctrl = '0; m_per = '0; m_wid = '0; m_cnt = '0; m_pa = '0; m_wa = '0;
            m_run = 0; m_tog = 0; m_t1 = 0; m_t2 = 0; m_tp = 0; m_e1 = 0; m_e2 = 0; m_ep = 0;
        end else begin
            te = edge_hit(m_ctrl[5:4], m_t2, m_tp);
            ee = edge_hit(m_ctrl[7:6], m_e2, m_ep);
            st = m_run && (m_ctrl[8] ? ee : cnt_tick);
            if (te) begin
                m_cnt = '0; m_run = 1; m_tog = 0; m_pa = m_per; m_wa = m_wid;
            end else if (st) begin
                if (m_cnt == m_pa) begin
                    m_cnt = '0; m_tog = ~m_tog; m_pa = m_per; m_wa = m_wid;
                end else begin
                    m_cnt = m_cnt + 1'b1;
                end
            end
            m_tp = m_t2; m_t2 = m_t1; m_t1 = trig_in;
            m_ep = m_e2; m_e2 = m_e1; m_e1 = evt_in;
            if (wr_en) begin
                case (addr)
                    2'd0:    m_ctrl = wdata[8:0];
                    2'd1:    m_per = wdata;
                    2'd2:    m_wid = wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock and compare every output with the model
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_bit("R4 R5 pwm0", pwm0, exp_pwm0());
        check_bit("R2 R3 R8 R10 pwm1", pwm1, exp_pwm1());
        if (addr == 2'd3)
            check_word("R1 R6 R7 R8 R9 count", rdata, exp_rdata(addr));
        else
            check_word("R11 readback", rdata, exp_rdata(addr));
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1; addr = a; wdata = d;
        step();
        wr_en = 0; addr = 2'd3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int active_cnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        check_bit("R12 pwm0 reset", pwm0, 1'b0);
        check_bit("R12 pwm1 reset", pwm1, 1'b0);
        check_word("R12 count reset", rdata, '0);
        for (int a = 0; a < 3; a++) begin
            addr = a[1:0];
            #1 check_word("R12 reg reset", rdata, '0);
        end
        addr = 2'd3;

        // R8: ticks before any trigger leave count at 0
        cnt_tick = 1;
        wr(2'd0, 16'h0015);           // oe0, oe1, rising trigger
        repeat (5) step();
        check_word("R8 idle count", rdata, '0);

        // R1 R2: period 4, width 2, tick every clock
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd2);
        trig_in = 1;
        repeat (3) step();
        check_word("R6 trigger latency", rdata, '0);
        active_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            if (pwm1) active_cnt++;
            step();
        end
        check_word("R1 R2 active steps in two cycles", active_cnt[W-1:0], 16'd4);

        // R10: new width mid-cycle is deferred (checked by model each step)
        wr(2'd2, 16'd5);
        repeat (12) step();

        // R11: write to count address ignored
        wr(2'd3, 16'hBEEF);
        repeat (2) step();

        // R7: count on both edges of the event pin
        wr(2'd0, 16'h01D5);
        cnt_tick = 0;
        for (int i = 0; i < 20; i++) begin
            evt_in = ~evt_in;
            step();
        end

        // Constrained random mix
        for (int i = 0; i < 6000; i++) begin
            cnt_tick = ($urandom % 2) == 0;
            if ($urandom % 40 == 0) trig_in = ~trig_in;
            if ($urandom % 3 == 0) evt_in = ~evt_in;
            if ($urandom % 16 == 0) begin
                logic [1:0] a;
                a = $urandom % 4;
                wr_en = 1; addr = a;
                case (a)
                    2'd0:    wdata = 16'($urandom % 512);
                    2'd1:    wdata = 16'($urandom % 8);
                    2'd2:    wdata = 16'($urandom % 10);
                    default: wdata = 16'($urandom);
                endcase
            end else begin
                wr_en = 0;
                addr = 2'($urandom % 4);
            end
            step();
        end
        wr_en = 0;

        // R12: reset mid-run returns everything to zero
        rst_n = 0;
        step();
        rst_n = 1; addr = 2'd3;
        step();
        check_word("R12 count after reset", rdata, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule